// File: doc/BRIEF.md
# Script-Driven Register Dump Engine

This block is a small bus master that runs a list of register operations kept in system memory. Software places the list in memory, programs its 64-bit starting address as two 32-bit halves, and starts the engine through a control register. The engine then works through the list one operation at a time. Each operation is 128 bits, stored as two 64-bit memory words. A read operation copies a run of internal registers into a memory buffer. A write operation loads a value into one or more internal registers.

The engine drives three ports. It reads script words and stores dumped values through a 64-bit memory master that uses byte strobes. It accesses the internal registers through a 32-bit register master. A CPU-facing port holds the base address and the control/status register. Every access on both master ports is a single request, which the engine holds until an acknowledge returns. A run ends in one of two ways: the engine reaches an operation made of two zero words, or the memory side reports an error. In both cases done is raised. An error response also raises the error flag.

Top module: `regdump_engine`

## Requirements
- R1: A start latches the 64-bit base from the CPU port. It is formed from offset 0 (bits 31:0) and offset 1 (bits 63:32). The first memory read is at the base, the second at base+8, and the next operation begins at base+16. Both words are fetched before any register access.
- R2: In the second operation word, bits [63:44] give the first register address, bits [15:0] give the dword count, and bit 21 selects the type (1 = write, 0 = read).
- R3: A read of count N reads registers A, A+1, …, A+N-1. Each value is stored as a 32-bit store at first-word address +4·k. A store to a byte address with bit 2 clear uses byte strobes 0x0F (low half of the 64-bit word). A store with bit 2 set uses 0xF0 (high half).
- R4: A write of count N writes the low 32 bits of the first word to registers A through A+N-1.
- R5: An operation whose two words are both zero ends the run with done set. It makes no register access and fetches nothing further.
- R6: Writing a value with bit 0 set to offset 2 starts the engine. Reading offset 2 returns busy in bit 0, done in bit 2 and error in bit 3.
- R7: A start written while the engine is busy has no effect. The running script completes unchanged.
- R8: A start that is accepted clears done and error on the next cycle and sets busy.
- R9: An error response on a fetch or a store aborts the run. Both done and error are set, and no later operation is carried out.
- R10: An operation with a count of zero makes no register or memory data access. Execution continues with the next operation.
- R11: A request on either master port is held with a stable address until it is acknowledged. The two ports are never requested at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CPU register write strobe |
| csr_addr | input | CSR_AW (2) | CPU register offset |
| csr_wdata | input | CSR_DW (32) | CPU write data |
| csr_rdata | output | CSR_DW (32) | CPU read data (combinational on csr_addr) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a store |
| mem_addr | output | MEM_AW (64) | Byte address, 8-byte aligned |
| mem_wdata | output | MEM_DW (64) | Store data (value on every lane) |
| mem_wstrb | output | MEM_DW/8 (8) | Store byte enables |
| mem_ack | input | 1 | Memory request completed |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | MEM_DW (64) | Fetched script word, valid with mem_ack |
| reg_req | output | 1 | Register request, held until reg_ack |
| reg_we | output | 1 | Register request is a write |
| reg_addr | output | REG_AW (20) | Register dword address |
| reg_wdata | output | REG_DW (32) | Register write data |
| reg_ack | input | 1 | Register request completed |
| reg_rdata | input | REG_DW (32) | Register read data, valid with reg_ack |

## Verification
A wrong operation pointer shows up at once as a fetch address that is not base+16·k. The next operation then runs against the wrong registers or the wrong buffer. An off-by-one remaining count shows within one operation: either an extra register access appears or the final dword is missing from the buffer. A wrong lane select shows as the wrong half of a memory word being overwritten. Stale done or error flags appear in the status read on the cycle after a start. A missed end marker shows as register accesses made after the zero operation.

// File: rtl/regdump_pkg.sv
package regdump_pkg;

   // operation word layout (second word of each 128-bit operation)
   localparam int OP_ADDR_LSB  = 44;
   localparam int OP_WRITE_BIT = 21;
   localparam int OP_CNT_LSB   = 0;

   // CPU register offsets
   localparam logic [1:0] CSR_BASE_LO = 2'd0;
   localparam logic [1:0] CSR_BASE_HI = 2'd1;
   localparam logic [1:0] CSR_CTRL    = 2'd2;

   // control/status bit positions
   localparam int CTRL_GO   = 0;
   localparam int STAT_BUSY = 0;
   localparam int STAT_DONE = 2;
   localparam int STAT_ERR  = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH0,
      ST_FETCH1,
      ST_DISPATCH,
      ST_REG,
      ST_STORE
   } seq_state_t;

endpackage

// File: rtl/regdump_opdec.sv
module regdump_opdec
   import regdump_pkg::*;
#(
   parameter int OP_W   = 64,
   parameter int REG_AW = 20,
   parameter int CNT_W  = 16
) (
   input  logic [OP_W-1:0]   word0,
   input  logic [OP_W-1:0]   word1,
   output logic              is_end,
   output logic              is_write,
   output logic [REG_AW-1:0] reg_addr,
   output logic [CNT_W-1:0]  count
);

   if (OP_ADDR_LSB + REG_AW > OP_W) begin : g_bad_addr
      $error("register address field exceeds operation word");
   end
   if (OP_CNT_LSB + CNT_W > OP_WRITE_BIT) begin : g_bad_cnt
      $error("count field overlaps type bit");
   end

   assign is_end   = (word0 == '0) && (word1 == '0);
   assign is_write = word1[OP_WRITE_BIT];
   assign reg_addr = word1[OP_ADDR_LSB +: REG_AW];
   assign count    = word1[OP_CNT_LSB +: CNT_W];

endmodule

// File: rtl/regdump_lane.sv
module regdump_lane #(
   parameter int MEM_AW = 64,
   parameter int MEM_DW = 64,
   parameter int REG_DW = 32
) (
   input  logic [MEM_AW-1:0]   byte_addr,
   input  logic [REG_DW-1:0]   data,
   output logic [MEM_AW-1:0]   word_addr,
   output logic [MEM_DW-1:0]   wdata,
   output logic [MEM_DW/8-1:0] wstrb
);

   localparam int LANES    = MEM_DW / REG_DW;
   localparam int LB       = REG_DW / 8;
   localparam int BYTE_OFF = $clog2(MEM_DW / 8);
   localparam int LANE_OFF = $clog2(LB);

   if (MEM_DW % REG_DW != 0 || REG_DW < 16) begin : g_bad_width
      $error("memory width must be a multiple of register width");
   end

   logic unused_lo;
   assign unused_lo = ^byte_addr[LANE_OFF-1:0];

   assign word_addr = {byte_addr[MEM_AW-1:BYTE_OFF], {BYTE_OFF{1'b0}}};

   for (genvar g = 0; g < LANES; g++) begin : g_rep
      assign wdata[g*REG_DW +: REG_DW] = data;
   end

   if (LANES == 1) begin : g_single
      assign wstrb = '1;
   end else begin : g_multi
      localparam int LSEL_W = $clog2(LANES);
      logic [LSEL_W-1:0] lane;
      assign lane = byte_addr[LANE_OFF +: LSEL_W];
      for (genvar g = 0; g < LANES; g++) begin : g_strb
         assign wstrb[g*LB +: LB] = {LB{lane == LSEL_W'(g)}};
      end
   end

endmodule

// File: rtl/regdump_csr.sv
module regdump_csr
   import regdump_pkg::*;
#(
   parameter int CSR_AW = 2,
   parameter int CSR_DW = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_we,
   input  logic [CSR_AW-1:0]   csr_addr,
   input  logic [CSR_DW-1:0]   csr_wdata,
   output logic [CSR_DW-1:0]   csr_rdata,
   input  logic                busy_i,
   input  logic                done_i,
   input  logic                err_i,
   output logic [2*CSR_DW-1:0] base_o,
   output logic                start_o
);

   if (CSR_AW < 2 || CSR_DW < 8) begin : g_bad_csr
      $error("CPU port too narrow for register map");
   end

   logic [CSR_DW-1:0] base_lo_q, base_hi_q;
   logic sel_lo, sel_hi, sel_ctrl;

   assign sel_lo   = csr_addr == CSR_AW'(CSR_BASE_LO);
   assign sel_hi   = csr_addr == CSR_AW'(CSR_BASE_HI);
   assign sel_ctrl = csr_addr == CSR_AW'(CSR_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
      end else if (csr_we) begin
         if (sel_lo) base_lo_q <= csr_wdata;
         if (sel_hi) base_hi_q <= csr_wdata;
      end
   end

   assign base_o  = {base_hi_q, base_lo_q};
   assign start_o = csr_we && sel_ctrl && csr_wdata[CTRL_GO] && !busy_i;

   always_comb begin
      csr_rdata = '0;
      if (sel_lo) csr_rdata = base_lo_q;
      else if (sel_hi) csr_rdata = base_hi_q;
      else if (sel_ctrl) begin
         csr_rdata[STAT_BUSY] = busy_i;
         csr_rdata[STAT_DONE] = done_i;
         csr_rdata[STAT_ERR]  = err_i;
      end
   end

endmodule

// File: rtl/regdump_seq.sv
module regdump_seq
   import regdump_pkg::*;
#(
   parameter int MEM_AW = 64,
   parameter int MEM_DW = 64,
   parameter int REG_AW = 20,
   parameter int REG_DW = 32,
   parameter int CNT_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [MEM_AW-1:0]   base_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                err_o,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [MEM_AW-1:0]   mem_addr_o,
   output logic [MEM_DW-1:0]   mem_wdata_o,
   output logic [MEM_DW/8-1:0] mem_wstrb_o,
   input  logic                mem_ack_i,
   input  logic                mem_err_i,
   input  logic [MEM_DW-1:0]   mem_rdata_i,
   output logic                reg_req_o,
   output logic                reg_we_o,
   output logic [REG_AW-1:0]   reg_addr_o,
   output logic [REG_DW-1:0]   reg_wdata_o,
   input  logic                reg_ack_i,
   input  logic [REG_DW-1:0]   reg_rdata_i
);

   localparam int          WORD_BYTES = MEM_DW / 8;
   localparam logic [MEM_AW-1:0] WORD_STEP = MEM_AW'(WORD_BYTES);
   localparam logic [MEM_AW-1:0] OP_STEP   = MEM_AW'(2 * WORD_BYTES);
   localparam logic [MEM_AW-1:0] LANE_STEP = MEM_AW'(REG_DW / 8);

   seq_state_t        state;
   logic [MEM_AW-1:0] fetch_ptr, dst_ptr;
   logic [MEM_DW-1:0] op_w0, op_w1;
   logic [REG_AW-1:0] cur_reg;
   logic [CNT_W-1:0]  remain;
   logic [REG_DW-1:0] wr_val, rd_hold;
   logic              op_is_wr, done_q, err_q;

   logic              dec_end, dec_wr;
   logic [REG_AW-1:0] dec_reg;
   logic [CNT_W-1:0]  dec_cnt;

   logic [MEM_AW-1:0]   st_addr;
   logic [MEM_DW-1:0]   st_wdata;
   logic [MEM_DW/8-1:0] st_wstrb;

   regdump_opdec #(.OP_W(MEM_DW), .REG_AW(REG_AW), .CNT_W(CNT_W)) u_dec (
      .word0(op_w0), .word1(op_w1),
      .is_end(dec_end), .is_write(dec_wr), .reg_addr(dec_reg), .count(dec_cnt)
   );

   regdump_lane #(.MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .REG_DW(REG_DW)) u_lane (
      .byte_addr(dst_ptr), .data(rd_hold),
      .word_addr(st_addr), .wdata(st_wdata), .wstrb(st_wstrb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         fetch_ptr <= '0;
         dst_ptr   <= '0;
         op_w0     <= '0;
         op_w1     <= '0;
         cur_reg   <= '0;
         remain    <= '0;
         wr_val    <= '0;
         rd_hold   <= '0;
         op_is_wr  <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start_i) begin
               fetch_ptr <= base_i;
               done_q    <= 1'b0;
               err_q     <= 1'b0;
               state     <= ST_FETCH0;
            end
            ST_FETCH0: if (mem_ack_i) begin
               if (mem_err_i) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  op_w0 <= mem_rdata_i;
                  state <= ST_FETCH1;
               end
            end
            ST_FETCH1: if (mem_ack_i) begin
               if (mem_err_i) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  op_w1 <= mem_rdata_i;
                  state <= ST_DISPATCH;
               end
            end
            ST_DISPATCH: begin
               if (dec_end) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  cur_reg  <= dec_reg;
                  remain   <= dec_cnt;
                  dst_ptr  <= op_w0;
                  wr_val   <= op_w0[REG_DW-1:0];
                  op_is_wr <= dec_wr;
                  if (dec_cnt == '0) begin
                     fetch_ptr <= fetch_ptr + OP_STEP;
                     state     <= ST_FETCH0;
                  end else begin
                     state <= ST_REG;
                  end
               end
            end
            ST_REG: if (reg_ack_i) begin
               cur_reg <= cur_reg + REG_AW'(1);
               if (op_is_wr) begin
                  remain <= remain - CNT_W'(1);
                  if (remain == CNT_W'(1)) begin
                     fetch_ptr <= fetch_ptr + OP_STEP;
                     state     <= ST_FETCH0;
                  end
               end else begin
                  rd_hold <= reg_rdata_i;
                  state   <= ST_STORE;
               end
            end
            ST_STORE: if (mem_ack_i) begin
               if (mem_err_i) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  dst_ptr <= dst_ptr + LANE_STEP;
                  remain  <= remain - CNT_W'(1);
                  if (remain == CNT_W'(1)) begin
                     fetch_ptr <= fetch_ptr + OP_STEP;
                     state     <= ST_FETCH0;
                  end else begin
                     state <= ST_REG;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = fetch_ptr;
      mem_wstrb_o = '0;
      case (state)
         ST_FETCH0: mem_req_o = 1'b1;
         ST_FETCH1: begin
            mem_req_o  = 1'b1;
            mem_addr_o = fetch_ptr + WORD_STEP;
         end
         ST_STORE: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = st_addr;
            mem_wstrb_o = st_wstrb;
         end
         default: ;
      endcase
   end

   assign mem_wdata_o = st_wdata;
   assign reg_req_o   = state == ST_REG;
   assign reg_we_o    = op_is_wr;
   assign reg_addr_o  = cur_reg;
   assign reg_wdata_o = wr_val;
   assign busy_o      = state != ST_IDLE;
   assign done_o      = done_q;
   assign err_o       = err_q;

   AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))
      else $error("memory request dropped or moved before ack"); // R11
   AST_REG_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o))
      else $error("register request dropped or moved before ack"); // R11
   AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req_o && reg_req_o))
      else $error("both master ports requested"); // R11
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && !done_o && !err_o)
      else $error("accepted start left stale status"); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o)
      else $error("done raised while busy"); // R6
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o)
      else $error("error without done"); // R9
   AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DISPATCH && dec_end |=> !reg_req_o && !mem_req_o)
      else $error("activity after end marker"); // R5

endmodule

// File: rtl/regdump_engine.sv
module regdump_engine
   import regdump_pkg::*;
#(
   parameter int CSR_AW = 2,
   parameter int CSR_DW = 32,
   parameter int MEM_AW = 64,
   parameter int MEM_DW = 64,
   parameter int REG_AW = 20,
   parameter int REG_DW = 32,
   parameter int CNT_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_we,
   input  logic [CSR_AW-1:0]   csr_addr,
   input  logic [CSR_DW-1:0]   csr_wdata,
   output logic [CSR_DW-1:0]   csr_rdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [MEM_AW-1:0]   mem_addr,
   output logic [MEM_DW-1:0]   mem_wdata,
   output logic [MEM_DW/8-1:0] mem_wstrb,
   input  logic                mem_ack,
   input  logic                mem_err,
   input  logic [MEM_DW-1:0]   mem_rdata,
   output logic                reg_req,
   output logic                reg_we,
   output logic [REG_AW-1:0]   reg_addr,
   output logic [REG_DW-1:0]   reg_wdata,
   input  logic                reg_ack,
   input  logic [REG_DW-1:0]   reg_rdata
);

   if (MEM_DW != 64) begin : g_bad_mem
      $error("operation format needs 64-bit memory words");
   end
   if (MEM_AW != 2 * CSR_DW) begin : g_bad_base
      $error("base address must be two CPU words");
   end

   logic              busy, done, err, start;
   logic [MEM_AW-1:0] base;

   regdump_csr #(.CSR_AW(CSR_AW), .CSR_DW(CSR_DW)) u_csr (
      .clk(clk), .rst_n(rst_n),
      .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .busy_i(busy), .done_i(done), .err_i(err),
      .base_o(base), .start_o(start)
   );

   regdump_seq #(
      .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .REG_AW(REG_AW), .REG_DW(REG_DW), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .base_i(base),
      .busy_o(busy), .done_o(done), .err_o(err),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_wstrb_o(mem_wstrb),
      .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
      .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
      .reg_wdata_o(reg_wdata), .reg_ack_i(reg_ack), .reg_rdata_i(reg_rdata)
   );

endmodule

// File: tb/regdump_engine_tb.sv
`timescale 1ns/1ps
module regdump_engine_tb;

   localparam logic [63:0] SENT = 64'hDEAD_BEEF_CAFE_F00D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [1:0]  csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        mem_req, mem_we;
   logic [63:0] mem_addr, mem_wdata;
   logic [7:0]  mem_wstrb;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        reg_req, reg_we;
   logic [19:0] reg_addr;
   logic [31:0] reg_wdata;
   logic        reg_ack = 1'b0;
   logic [31:0] reg_rdata = '0;

   // bench models
   logic [63:0] mem [0:511];
   logic [31:0] rmodel [0:255];
   logic        bd_we = 1'b0, bd_clr = 1'b0, log_clr = 1'b0;
   logic [8:0]  bd_idx = '0;
   logic [63:0] bd_data = '0;
   logic        err_en = 1'b0;
   logic [63:0] err_addr = '0;
   logic [63:0] rd_log [0:3];
   int          rd_n = 0;
   int          reg_n = 0;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   regdump_engine u_dut (
      .clk(clk), .rst_n(rst_n),
      .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_ack(reg_ack), .reg_rdata(reg_rdata)
   );

   function automatic logic [31:0] rm(input int i);
      return 32'h5A00_0000 | 32'(i);
   endfunction
   function automatic logic [63:0] op_rd(input logic [19:0] r, input logic [15:0] n);
      return {r, 28'd0, n};
   endfunction
   function automatic logic [63:0] op_wr(input logic [19:0] r, input logic [15:0] n);
      return {r, 22'd0, 1'b1, 5'd0, n};
   endfunction

   // memory responder
   always @(posedge clk) begin
      if (bd_clr) for (int i = 0; i < 512; i++) mem[i] <= SENT;
      if (bd_we) mem[bd_idx] <= bd_data;
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      if (log_clr) rd_n <= 0;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (err_en && mem_addr == err_addr) mem_err <= 1'b1;
         else if (mem_we) begin
            for (int b = 0; b < 8; b++)
               if (mem_wstrb[b]) mem[mem_addr[11:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[11:3]];
            if (rd_n < 4) rd_log[rd_n] <= mem_addr;
            rd_n <= rd_n + 1;
         end
      end
   end

   // register responder
   always @(posedge clk) begin
      reg_ack <= 1'b0;
      if (log_clr) reg_n <= 0;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) rmodel[i] <= rm(i);
      end else if (reg_req && !reg_ack) begin
         reg_ack <= 1'b1;
         reg_n   <= reg_n + 1;
         if (reg_we) rmodel[reg_addr[7:0]] <= reg_wdata;
         else reg_rdata <= rmodel[reg_addr[7:0]];
      end
   end

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic poke(input int idx, input logic [63:0] d);
      @(negedge clk);
      bd_we = 1'b1; bd_idx = 9'(idx); bd_data = d;
      @(negedge clk);
      bd_we = 1'b0;
   endtask

   task automatic put_op(input int byte_addr, input logic [63:0] w0, input logic [63:0] w1);
      poke(byte_addr >> 3, w0);
      poke((byte_addr >> 3) + 1, w1);
   endtask

   task automatic fresh();
      @(negedge clk);
      bd_clr = 1'b1; log_clr = 1'b1;
      @(negedge clk);
      bd_clr = 1'b0; log_clr = 1'b0;
   endtask

   task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic start_at(input logic [31:0] hi, input logic [31:0] lo);
      csr_write(2'd0, lo);
      csr_write(2'd1, hi);
      csr_write(2'd2, 32'h1);
   endtask

   task automatic wait_done(output logic [31:0] st);
      int n = 0;
      st = '0;
      while (n < 3000) begin
         csr_read(2'd2, st);
         if (st[2]) break;
         n++;
      end
      if (!st[2]) chk(64'(st), 64'h4, "R6 run never finished");
   endtask

   task automatic t_reset();
      logic [31:0] v;
      csr_read(2'd2, v);
      chk(64'(v), 64'h0, "R6 status after reset");
      chk({63'd0, mem_req | reg_req}, 64'd0, "R11 no request after reset");
   endtask

   task automatic t_read_multi();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'h800, op_rd(20'h10, 16'd3));
      put_op(32'h010, 64'd0, 64'd0);
      start_at(0, 0);
      wait_done(st);
      chk(64'(st), 64'h4, "R6 status after good run");
      chk(mem[256], {rm(16'h11), rm(16'h10)}, "R3 first word of dump");
      chk(mem[257], {SENT[63:32], rm(16'h12)}, "R3 third dword, high half kept");
      chk(64'(reg_n), 64'd3, "R2 read count field honoured");
   endtask

   task automatic t_read_odd();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'h904, op_rd(20'h05, 16'd1));
      put_op(32'h010, 64'd0, 64'd0);
      start_at(0, 0);
      wait_done(st);
      chk(mem[288], {rm(5), SENT[31:0]}, "R3 odd dword lands in high lane");
   endtask

   task automatic t_write();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'hFFFF_FFFF_1234_5678, op_wr(20'h40, 16'd1));
      put_op(32'h010, 64'h0000_0000_ABCD_0001, op_wr(20'h50, 16'd3));
      put_op(32'h020, 64'd0, 64'd0);
      start_at(0, 0);
      wait_done(st);
      chk(64'(rmodel[8'h40]), 64'h1234_5678, "R4 single write value");
      chk(64'(rmodel[8'h52]), 64'hABCD_0001, "R4 repeated write last register");
      chk(64'(rmodel[8'h53]), 64'(rm(16'h53)), "R4 write stops after count");
      chk(mem[256], SENT, "R2 write type stores nothing");
   endtask

   task automatic t_count0();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'h980, op_rd(20'h20, 16'd0));
      put_op(32'h010, 64'h77, op_wr(20'h60, 16'd1));
      put_op(32'h020, 64'd0, 64'd0);
      start_at(0, 0);
      wait_done(st);
      chk(64'(reg_n), 64'd1, "R10 zero count makes no register access");
      chk(mem[304], SENT, "R10 zero count stores nothing");
      chk(64'(rmodel[8'h60]), 64'h77, "R10 next operation still runs");
   endtask

   task automatic t_end_stop();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'd0, 64'd0);
      put_op(32'h010, 64'h1, op_wr(20'h70, 16'd1));
      start_at(0, 0);
      wait_done(st);
      chk(64'(st), 64'h4, "R5 end marker sets done only");
      chk(64'(reg_n), 64'd0, "R5 no register access at end marker");
      chk(64'(rd_n), 64'd2, "R5 nothing fetched after end marker");
   endtask

   task automatic t_fetch_err();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'h5, op_wr(20'hA0, 16'd1));
      put_op(32'h010, 64'd0, 64'd0);
      err_en = 1'b1; err_addr = 64'h0;
      start_at(0, 0);
      wait_done(st);
      err_en = 1'b0;
      chk(64'(st), 64'hC, "R9 fetch error sets done and error");
      chk(64'(rmodel[8'hA0]), 64'(rm(16'hA0)), "R9 aborted operation not executed");
   endtask

   task automatic t_done_clear();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'h1, op_wr(20'hC0, 16'd1));
      put_op(32'h010, 64'd0, 64'd0);
      start_at(0, 0);
      csr_read(2'd2, st);
      chk(64'(st), 64'h1, "R8 start clears done and error");
      wait_done(st);
      chk(64'(st), 64'h4, "R8 clean finish after earlier error");
   endtask

   task automatic t_store_err();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'hA00, op_rd(20'h10, 16'd2));
      put_op(32'h010, 64'h9, op_wr(20'hA8, 16'd1));
      put_op(32'h020, 64'd0, 64'd0);
      err_en = 1'b1; err_addr = 64'hA00;
      start_at(0, 0);
      wait_done(st);
      err_en = 1'b0;
      chk(64'(st), 64'hC, "R9 store error sets done and error");
      chk(64'(reg_n), 64'd1, "R9 abort stops the read run");
      chk(64'(rmodel[8'hA8]), 64'(rm(16'hA8)), "R9 later operation skipped");
   endtask

   task automatic t_busy_start();
      logic [31:0] st;
      fresh();
      put_op(32'h000, 64'hAAAA_0001, op_wr(20'h80, 16'd4));
      put_op(32'h010, 64'd0, 64'd0);
      put_op(32'h200, 64'hBBBB, op_wr(20'h90, 16'd1));
      put_op(32'h210, 64'd0, 64'd0);
      start_at(0, 0);
      csr_write(2'd0, 32'h200);
      csr_write(2'd2, 32'h1);
      wait_done(st);
      chk(64'(rmodel[8'h83]), 64'hAAAA_0001, "R7 running script completes");
      chk(64'(rmodel[8'h90]), 64'(rm(16'h90)), "R7 start while busy ignored");
      chk(64'(reg_n), 64'd4, "R7 no extra register accesses");
   endtask

   task automatic t_base_hi();
      logic [31:0] st;
      fresh();
      put_op(32'h100, 64'h33, op_wr(20'hB0, 16'd1));
      put_op(32'h110, 64'd0, 64'd0);
      start_at(32'h1, 32'h100);
      wait_done(st);
      chk(rd_log[0], 64'h1_0000_0100, "R1 first fetch at base");
      chk(rd_log[1], 64'h1_0000_0108, "R1 second fetch at base+8");
      chk(rd_log[2], 64'h1_0000_0110, "R1 next operation at base+16");
      chk(64'(rmodel[8'hB0]), 64'h33, "R1 operation from high base runs");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read_multi();
      t_read_odd();
      t_write();
      t_count0();
      t_end_stop();
      t_fetch_err();
      t_done_clear();
      t_store_err();
      t_busy_start();
      t_base_hi();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule